// File: doc/BRIEF.md
# Clock-Enable Down Sampler

This block lowers the rate of a sample stream by an integer factor inside a design that runs on one clock. Sample rates are set by single-cycle enable pulses. An input-rate enable marks each valid input sample. An output-rate enable, produced by the same enable generator, goes high on the cycle of every M-th input enable. That cycle closes a frame of M samples. From each frame the block keeps exactly one sample and drops the rest.

Two parameters choose the variant. The frame policy keeps either the final sample of a frame or its opening sample. Keeping the opening sample needs one extra capture register. The latency mode is either one cycle or zero. In the one-cycle mode the kept sample appears on the output register the cycle after the output enable. In the zero-latency mode a shutter multiplexer sends the kept sample to the output during the output-enable cycle itself, and holds the previous kept sample at all other times. The shutter select comes from a registered last-slot flag. The data path through the shutter is combinational, so a downstream register sees input-to-output logic in that mode.

Top module: `cedec_downsampler`

## Requirements
- R1: While the active-low reset is asserted, the output is zero. The held sample and the frame position also clear, so the first input enable after reset opens a new frame.
- R2: The output-enable input is high only on an input-enable cycle at frame slot M-1, where slots count input enables from 0. Exactly one sample of each M-sample frame reaches the output.
- R3: With one-cycle latency and keep-last, the output in the cycle after an output enable equals the data input sampled in that output-enable cycle.
- R4: With one-cycle latency and keep-first, the output in the cycle after an output enable equals the data input of the frame's slot-0 input-enable cycle.
- R5: With zero latency, during an output-enable cycle the output equals the frame's kept sample in that same cycle. For keep-last this is the current data input.
- R6: With zero latency, on cycles without an output enable the output equals the sample kept at the most recent output enable, or zero if there has been none since reset.
- R7: With one-cycle latency, the output does not change in any cycle that does not follow an output enable. Data input changes while the input enable is low never reach the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, the fastest rate in the design |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| in_en | input | 1 | Input-rate enable; marks a valid sample on din |
| out_en | input | 1 | Output-rate enable; high with every M-th in_en |
| din | input | DATA_W | Input sample |
| dout | output | DATA_W | Decimated output sample |

## Verification
A wrong frame position shows up at the output within one frame. In keep-first mode the wrong input sample gets captured, and the mismatch appears the cycle after the next output enable, or in the same cycle in zero-latency mode. A held register that updates off its enable changes the output in a cycle where it must stay fixed, and that is visible on the next edge. A misaligned shutter flag either lets live data through outside an output-enable cycle or holds stale data during one, and in both cases the error is visible combinationally in that cycle.

// File: rtl/cedec_pkg.sv
package cedec_pkg;

  typedef enum logic {
    KEEP_LAST  = 1'b0,
    KEEP_FIRST = 1'b1
  } keep_pol_e;

  typedef enum logic {
    LAT_ONE  = 1'b0,
    LAT_ZERO = 1'b1
  } lat_mode_e;

  // width of a slot counter for a frame of m samples (at least one bit)
  function automatic int unsigned slot_width(input int unsigned m);
    return (m > 1) ? $clog2(m) : 1;
  endfunction

endpackage

// File: rtl/cedec_frame_ctr.sv
// Counts input enables within a frame and flags the frame's final slot one
// cycle ahead, so the shutter select comes straight from a flop.
module cedec_frame_ctr #(
  parameter int unsigned FACTOR = 4,
  parameter int unsigned CNT_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_en,
  output logic [CNT_W-1:0] slot_q,
  output logic             last_slot_q
);

  localparam logic [CNT_W-1:0] LAST_SLOT  = CNT_W'(FACTOR - 1);
  localparam logic             LAST_RESET = (FACTOR == 1);

  logic [CNT_W-1:0] slot_d;
  logic             last_slot_d;

  always_comb begin
    slot_d = slot_q;
    if (in_en) begin
      slot_d = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
    end
    last_slot_d = (slot_d == LAST_SLOT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q      <= '0;
      last_slot_q <= LAST_RESET;
    end else begin
      slot_q      <= slot_d;
      last_slot_q <= last_slot_d;
    end
  end

endmodule

// File: rtl/cedec_first_hold.sv
// Keep-first policy: captures the slot-0 sample and presents it as the
// frame's live sample; at slot 0 the current input is already that sample.
module cedec_first_hold #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_en,
  input  logic [CNT_W-1:0]  slot,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] live
);

  logic              at_first;
  logic [DATA_W-1:0] first_q;
  logic [DATA_W-1:0] first_d;

  assign at_first = (slot == '0);

  always_comb begin
    first_d = first_q;
    if (in_en && at_first) begin
      first_d = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
    end else begin
      first_q <= first_d;
    end
  end

  assign live = at_first ? din : first_q;

endmodule

// File: rtl/cedec_out_reg.sv
// Output-rate register: loads the live sample on the output enable.
module cedec_out_reg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] live,
  output logic [DATA_W-1:0] hold_q
);

  logic [DATA_W-1:0] hold_d;

  always_comb begin
    hold_d = hold_q;
    if (load) begin
      hold_d = live;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else begin
      hold_q <= hold_d;
    end
  end

endmodule

// File: rtl/cedec_shutter.sv
// Zero-latency stage: the held register plus an output multiplexer whose
// select is the registered last-slot flag qualified by the input enable.
module cedec_shutter #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_en,
  input  logic              last_slot_q,
  input  logic              load,
  input  logic [DATA_W-1:0] live,
  output logic [DATA_W-1:0] dout
);

  logic              open_now;
  logic [DATA_W-1:0] held;

  cedec_out_reg #(
    .DATA_W (DATA_W)
  ) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .live   (live),
    .hold_q (held)
  );

  assign open_now = last_slot_q & in_en;
  assign dout     = open_now ? live : held;

endmodule

// File: rtl/cedec_downsampler.sv
module cedec_downsampler #(
  parameter int unsigned           DATA_W  = 16,
  parameter int unsigned           FACTOR  = 4,
  parameter cedec_pkg::keep_pol_e  KEEP    = cedec_pkg::KEEP_LAST,
  parameter cedec_pkg::lat_mode_e  LATENCY = cedec_pkg::LAT_ONE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_en,
  input  logic              out_en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  localparam int unsigned CNT_W = cedec_pkg::slot_width(FACTOR);

  logic [CNT_W-1:0]  slot_w;
  logic              last_slot_w;
  logic [DATA_W-1:0] live_smp;

  cedec_frame_ctr #(
    .FACTOR (FACTOR),
    .CNT_W  (CNT_W)
  ) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_en       (in_en),
    .slot_q      (slot_w),
    .last_slot_q (last_slot_w)
  );

  if (KEEP == cedec_pkg::KEEP_FIRST) begin : g_keep_first
    cedec_first_hold #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
    ) u_first (
      .clk   (clk),
      .rst_n (rst_n),
      .in_en (in_en),
      .slot  (slot_w),
      .din   (din),
      .live  (live_smp)
    );
  end else begin : g_keep_last
    assign live_smp = din;
  end

  if (LATENCY == cedec_pkg::LAT_ZERO) begin : g_zero_lat
    cedec_shutter #(
      .DATA_W (DATA_W)
    ) u_shut (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_en       (in_en),
      .last_slot_q (last_slot_w),
      .load        (out_en),
      .live        (live_smp),
      .dout        (dout)
    );
  end else begin : g_one_lat
    cedec_out_reg #(
      .DATA_W (DATA_W)
    ) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (out_en),
      .live   (live_smp),
      .hold_q (dout)
    );
  end

endmodule

// File: rtl/cedec_downsampler_chk.sv
module cedec_downsampler_chk #(
  parameter int unsigned           DATA_W  = 16,
  parameter int unsigned           FACTOR  = 4,
  parameter int unsigned           CNT_W   = 2,
  parameter cedec_pkg::keep_pol_e  KEEP    = cedec_pkg::KEEP_LAST,
  parameter cedec_pkg::lat_mode_e  LATENCY = cedec_pkg::LAT_ONE
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_en,
  input logic              out_en,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] dout,
  input logic [CNT_W-1:0]  slot,
  input logic              last_slot,
  input logic [DATA_W-1:0] live
);

  // R1: output is zero while reset is held
  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |-> (dout == '0));

  // R2: output enable only at the final slot of a frame, with an input enable
  a_r2_enable_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> (in_en && last_slot));

  // R2: slot index stays inside the frame
  a_r2_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(slot) < FACTOR);

  if (LATENCY == cedec_pkg::LAT_ONE) begin : g_one
    if (KEEP == cedec_pkg::KEEP_LAST) begin : g_last
      // R3: output carries the input from the output-enable cycle
      a_r3_keep_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |=> (dout == $past(din)));
    end else begin : g_first
      // R4: output carries the frame's captured opening sample
      a_r4_keep_first: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |=> (dout == $past(live)));
    end
    // R7: output only moves after an output enable
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |=> $stable(dout));
  end else begin : g_zero
    // R5: shutter passes the kept sample in the enable cycle
    a_r5_shutter_open: assert property (@(posedge clk) disable iff (!rst_n)
      out_en |-> (dout == live));
    // R6: between enables the shutter shows a fixed held value
    a_r6_shutter_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_en && !$past(out_en)) |-> $stable(dout));
  end

endmodule

bind cedec_downsampler cedec_downsampler_chk #(
  .DATA_W  (DATA_W),
  .FACTOR  (FACTOR),
  .CNT_W   (CNT_W),
  .KEEP    (KEEP),
  .LATENCY (LATENCY)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_en     (in_en),
  .out_en    (out_en),
  .din       (din),
  .dout      (dout),
  .slot      (slot_w),
  .last_slot (last_slot_w),
  .live      (live_smp)
);

// File: tb/cedec_downsampler_tb_top.sv
module cedec_downsampler_tb_top;
  import cedec_pkg::*;

  localparam int W = 16;
  localparam int M = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic         in_en = 1'b0;
  logic         out_en = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] q_kl1, q_kf1, q_klz, q_kfz;

  always #2 clk = ~clk;   // 250 MHz

  cedec_downsampler #(.DATA_W(W), .FACTOR(M), .KEEP(KEEP_LAST), .LATENCY(LAT_ONE))
    dut_i (.clk(clk), .rst_n(rst_n), .in_en(in_en), .out_en(out_en), .din(din), .dout(q_kl1));
  cedec_downsampler #(.DATA_W(W), .FACTOR(M), .KEEP(KEEP_FIRST), .LATENCY(LAT_ONE))
    dut_kf1_i (.clk(clk), .rst_n(rst_n), .in_en(in_en), .out_en(out_en), .din(din), .dout(q_kf1));
  cedec_downsampler #(.DATA_W(W), .FACTOR(M), .KEEP(KEEP_LAST), .LATENCY(LAT_ZERO))
    dut_klz_i (.clk(clk), .rst_n(rst_n), .in_en(in_en), .out_en(out_en), .din(din), .dout(q_klz));
  cedec_downsampler #(.DATA_W(W), .FACTOR(M), .KEEP(KEEP_FIRST), .LATENCY(LAT_ZERO))
    dut_kfz_i (.clk(clk), .rst_n(rst_n), .in_en(in_en), .out_en(out_en), .din(din), .dout(q_kfz));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model state
  int           m_slot = 0;
  logic [W-1:0] m_first = '0;
  logic [W-1:0] m_hold_kl = '0;
  logic [W-1:0] m_hold_kf = '0;
  bit           prev_out = 1'b0;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] first_live(input logic [W-1:0] d);
    return (m_slot == 0) ? d : m_first;
  endfunction

  task automatic model_clear();
    m_slot = 0; m_first = '0; m_hold_kl = '0; m_hold_kf = '0; prev_out = 1'b0;
  endtask

  // one clock of stimulus: drive at negedge, check before the next posedge
  task automatic cyc(input bit e, input logic [W-1:0] d);
    logic [W-1:0] lf;
    @(negedge clk);
    in_en  = e;
    din    = d;
    out_en = e && (m_slot == M-1);   // R2: enable with every M-th in_en
    #1;
    lf = first_live(d);
    chk(prev_out ? "R2,R3 latency-one keep-last" : "R7 latency-one keep-last", q_kl1, m_hold_kl);
    chk(prev_out ? "R4 latency-one keep-first"   : "R7 latency-one keep-first", q_kf1, m_hold_kf);
    chk(out_en ? "R5 zero-latency keep-last"  : "R6 zero-latency keep-last",  q_klz, out_en ? d  : m_hold_kl);
    chk(out_en ? "R5 zero-latency keep-first" : "R6 zero-latency keep-first", q_kfz, out_en ? lf : m_hold_kf);
    if (out_en) begin
      m_hold_kl = d;
      m_hold_kf = lf;
    end
    if (e && m_slot == 0) m_first = d;
    if (e) m_slot = (m_slot == M-1) ? 0 : m_slot + 1;
    prev_out = out_en;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n  = 1'b0;
    in_en  = 1'b0;
    out_en = 1'b0;
    din    = W'($urandom);
    #1;
    chk("R1 reset latency-one keep-last",  q_kl1, '0);
    chk("R1 reset latency-one keep-first", q_kf1, '0);
    chk("R1 reset zero-latency keep-last", q_klz, '0);
    chk("R1 reset zero-latency keep-first", q_kfz, '0);
    model_clear();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    #1 rst_n = 1'b0;
    do_reset();
    // back-to-back input enables, three frames
    for (int i = 0; i < 12; i++) cyc(1'b1, W'(16'h0100 + i));
    // sparse enables with data moving on idle cycles (R7)
    for (int i = 0; i < 15; i++) cyc((i % 3) == 0, W'(16'hA000 + i));
    // extreme values
    for (int i = 0; i < 8; i++) cyc(1'b1, (i % 2) ? '1 : '0);
    // random traffic, dense
    for (int i = 0; i < 3000; i++) cyc($urandom_range(0, 99) < 60, W'($urandom));
    // reset in the middle of a frame; next frame must restart at slot 0 (R1)
    cyc(1'b1, W'(16'h1111));
    cyc(1'b1, W'(16'h2222));
    do_reset();
    for (int i = 0; i < 8; i++) cyc(1'b1, W'(16'h5500 + i));
    // random traffic, sparse
    for (int i = 0; i < 1000; i++) cyc($urandom_range(0, 99) < 20, W'($urandom));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: all requirements, actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule